// File: doc/BRIEF.md
# Link-side transmit handshake controller

This block sits on the link side of a parallel PHY-link connection for a serial bus and handles sending only. When a packet is pending, it raises a request line toward the PHY. It then watches the shared 2-bit control lane until the PHY grants the bus. After the PHY's one-clock idle, the link takes over the control and data pins. If the byte source is not ready yet, the link holds the interface. Once data is available, it streams each byte as 4-bit nibbles at one nibble per clock.

At the end of a packet, the link either releases the bus or keeps it for a further packet. Releasing means one idle clock and then tri-stating the pins. Keeping the bus means one hold clock and then waiting for a fresh grant, with no new arbitration. Chaining is only allowed at the speed latched for the first packet. Tri-state pins appear as value outputs plus output enables. Bytes arrive on a ready/valid source that carries a last-byte marker. A chain-next input and the speed input are sampled together with the last byte.

Top module: `lk_tx_ctrl`

## Requirements
- R1: A pulse on `tx_start` while the block is released raises `lreq` on the next clock. `lreq` stays high until a clock in which `ctl_i` = 11 (grant) is seen, and is low from the clock after that.
- R2: `ctl_oe` and `d_oe` stay low while the PHY keeps driving 11. They first rise on the clock after the first `ctl_i` = 00 that follows a grant.
- R3: After taking the bus, while the source has no valid byte, the link drives `ctl_o` = 01 (hold) with `d_o` = 0000. If a byte is valid in the PHY's idle clock, the link skips hold and transmits at once.
- R4: Every data clock drives `ctl_o` = 10 (transmit). Each byte takes two clocks, sending bits [7:4] first and bits [3:0] second, with no gap between consecutive bytes of a packet.
- R5: After the last nibble of a packet that is not chained, the link drives `ctl_o` = 00 with `d_o` = 0000 for exactly one clock, and then both enables go low.
- R6: If `chain_next` is high when the last byte is accepted (speed unchanged), the packet ends with one clock of `ctl_o` = 01. The pins are then released and `lreq` stays low. The next packet starts after a new 11 followed by 00 from the PHY.
- R7: If `chain_next` is high at the last byte but `tx_speed` differs from the value latched at `tx_start`, `err_speed` pulses for one clock. That clock is the one in which the first nibble of that byte is on the pins. The packet then ends with idle (00) instead of hold.
- R8: If no valid byte is present when the last nibble of a non-final byte is sent, the next clock drives `ctl_o` = 00 and `err_underrun` is high for that one clock. The pins are then released.
- R9: While `rst_n` is low, `lreq`, `ctl_oe`, `d_oe`, `src_ready`, `err_speed` and `err_underrun` are all low.
- R10: A `tx_start` pulse while a packet is in flight has no effect: `lreq` stays low after that packet ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Pulse: a packet is pending, ask for the bus |
| tx_speed | input | SPD_W | Speed code, latched at start and compared at a chained last byte |
| chain_next | input | 1 | Sampled with the last byte: keep the bus for another packet |
| src_data | input | BYTE_W | Byte from the source |
| src_valid | input | 1 | Source byte valid |
| src_last | input | 1 | Marks the final byte of a packet |
| src_ready | output | 1 | Byte accepted when high together with src_valid |
| ctl_i | input | 2 | Control lane value driven by the PHY |
| ctl_o | output | 2 | Control lane value driven by the link |
| ctl_oe | output | 1 | Link drives the control lane |
| d_o | output | NIB_W | Data lane value |
| d_oe | output | 1 | Link drives the data lane |
| lreq | output | 1 | Bus request toward the PHY |
| err_speed | output | 1 | One-clock flag: chained packet asked for another speed |
| err_underrun | output | 1 | One-clock flag: source stalled inside a packet |

## Verification
The bench builds the block with the defaults: an 8-bit byte, a 4-bit nibble and a 2-bit speed code. Two nibbles per byte make the shifter's counter and its upper-then-lower order visible on `d_o`. The 2-bit speed gives a distinct value with which the chained-speed mismatch can be provoked. With these values, a short cycle table reaches every hold, transmit, idle and chained-hold state. Directed runs then cover the underrun and speed-error paths.

// File: rtl/lk_tx_pkg.sv
package lk_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_GRANT,
    ST_HOLD,
    ST_TX,
    ST_END,
    ST_REGRANT
  } lk_st_e;

  localparam logic [1:0] CTL_IDLE  = 2'b00;
  localparam logic [1:0] CTL_HOLD  = 2'b01;
  localparam logic [1:0] CTL_TX    = 2'b10;
  localparam logic [1:0] CTL_GRANT = 2'b11;

endpackage

// File: rtl/lk_tx_shift.sv
module lk_tx_shift #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              sh,
  input  logic [BYTE_W-1:0] din,
  output logic [NIB_W-1:0]  nib,
  output logic              nib_last
);

  localparam int NPB = BYTE_W / NIB_W;
  localparam int CW  = (NPB > 1) ? $clog2(NPB) : 1;

  logic [BYTE_W-1:0] sh_q, sh_n;

  always_comb begin
    sh_n = sh_q;
    if (ld)      sh_n = din;
    else if (sh) sh_n = sh_q << NIB_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (ld || sh) sh_q <= sh_n;
  end

  assign nib = sh_q[BYTE_W-1 -: NIB_W];

  generate
    if (NPB == 1) begin : g_single
      assign nib_last = 1'b1;
    end else begin : g_count
      logic [CW-1:0] cnt_q, cnt_n;
      always_comb begin
        cnt_n = cnt_q;
        if (ld)      cnt_n = '0;
        else if (sh) cnt_n = cnt_q + CW'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (ld || sh) cnt_q <= cnt_n;
      end
      assign nib_last = (cnt_q == CW'(NPB - 1));
    end
  endgenerate

  // R4: a byte load never coincides with a nibble shift
  p_ld_sh_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld && sh));

endmodule

// File: rtl/lk_tx_fsm.sv
module lk_tx_fsm
  import lk_tx_pkg::*;
#(
  parameter int SPD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_start,
  input  logic [SPD_W-1:0] tx_speed,
  input  logic             chain_next,
  input  logic             src_valid,
  input  logic             src_last,
  input  logic [1:0]       ctl_i,
  input  logic             nib_last,
  output logic             src_ready,
  output logic             ld,
  output logic             sh,
  output logic             drive,
  output logic             tx_active,
  output logic [1:0]       ctl_o,
  output logic             lreq,
  output logic             err_speed,
  output logic             err_underrun
);

  lk_st_e st_q, st_n;
  logic [SPD_W-1:0] spd_q;
  logic last_q, hold_q, err_spd_q, err_und_q;
  logic take, spd_bad, und_n;

  assign src_ready = ((st_q == ST_GRANT) && (ctl_i == CTL_IDLE)) ||
                     (st_q == ST_HOLD) ||
                     ((st_q == ST_TX) && nib_last && !last_q);
  assign take    = src_ready && src_valid;
  assign ld      = take;
  assign spd_bad = take && src_last && chain_next && (tx_speed != spd_q);
  assign und_n   = (st_q == ST_TX) && nib_last && !last_q && !src_valid;

  always_comb begin
    st_n = st_q;
    sh   = 1'b0;
    case (st_q)
      ST_IDLE:    if (tx_start) st_n = ST_REQ;
      ST_REQ:     if (ctl_i == CTL_GRANT) st_n = ST_GRANT;
      ST_GRANT:   if (ctl_i == CTL_IDLE) st_n = take ? ST_TX : ST_HOLD;
      ST_HOLD:    if (take) st_n = ST_TX;
      ST_TX: begin
        if (!nib_last)   sh   = 1'b1;
        else if (last_q) st_n = ST_END;
        else if (!take)  st_n = ST_END;
      end
      ST_END:     st_n = hold_q ? ST_REGRANT : ST_IDLE;
      ST_REGRANT: if (ctl_i == CTL_GRANT) st_n = ST_GRANT;
      default:    st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      spd_q     <= '0;
      last_q    <= 1'b0;
      hold_q    <= 1'b0;
      err_spd_q <= 1'b0;
      err_und_q <= 1'b0;
    end else begin
      st_q      <= st_n;
      err_spd_q <= spd_bad;
      err_und_q <= und_n;
      if ((st_q == ST_IDLE) && tx_start) spd_q <= tx_speed;
      if (take) begin
        last_q <= src_last;
        hold_q <= src_last && chain_next && (tx_speed == spd_q);
      end
    end
  end

  assign drive     = (st_q == ST_HOLD) || (st_q == ST_TX) || (st_q == ST_END);
  assign tx_active = (st_q == ST_TX);
  assign lreq      = (st_q == ST_REQ);
  assign err_speed    = err_spd_q;
  assign err_underrun = err_und_q;

  always_comb begin
    case (st_q)
      ST_HOLD: ctl_o = CTL_HOLD;
      ST_TX:   ctl_o = CTL_TX;
      ST_END:  ctl_o = hold_q ? CTL_HOLD : CTL_IDLE;
      default: ctl_o = CTL_IDLE;
    endcase
  end

  // R1: the request drops once the grant code is seen
  p_lreq_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq && ctl_i == CTL_GRANT) |=> !lreq);

  // R2: the link only starts driving right after a PHY idle clock
  p_take_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(ctl_i) == CTL_IDLE);

  // R4: transmit is never followed directly by release
  p_tx_continue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && ctl_o == CTL_TX) |=> drive);

  // R5: the closing code lasts one clock, then the pins are released
  p_release_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_END) |=> !drive);

  // R7: a speed error never coincides with an underrun
  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_speed |-> !err_underrun);

  // R8: an underrun flag follows a transmit clock
  p_underrun_after_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_underrun) |-> ctl_o == CTL_IDLE && drive);

endmodule

// File: rtl/lk_tx_ctrl.sv
module lk_tx_ctrl
  import lk_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  parameter int SPD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [SPD_W-1:0]  tx_speed,
  input  logic              chain_next,
  input  logic [BYTE_W-1:0] src_data,
  input  logic              src_valid,
  input  logic              src_last,
  output logic              src_ready,
  input  logic [1:0]        ctl_i,
  output logic [1:0]        ctl_o,
  output logic              ctl_oe,
  output logic [NIB_W-1:0]  d_o,
  output logic              d_oe,
  output logic              lreq,
  output logic              err_speed,
  output logic              err_underrun
);

  logic ld, sh, nib_last, drive, tx_active;
  logic [NIB_W-1:0] nib;

  lk_tx_fsm #(.SPD_W(SPD_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_start     (tx_start),
    .tx_speed     (tx_speed),
    .chain_next   (chain_next),
    .src_valid    (src_valid),
    .src_last     (src_last),
    .ctl_i        (ctl_i),
    .nib_last     (nib_last),
    .src_ready    (src_ready),
    .ld           (ld),
    .sh           (sh),
    .drive        (drive),
    .tx_active    (tx_active),
    .ctl_o        (ctl_o),
    .lreq         (lreq),
    .err_speed    (err_speed),
    .err_underrun (err_underrun)
  );

  lk_tx_shift #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld),
    .sh       (sh),
    .din      (src_data),
    .nib      (nib),
    .nib_last (nib_last)
  );

  assign ctl_oe = drive;
  assign d_oe   = drive;
  assign d_o    = tx_active ? nib : '0;

  // R3: data lines are zero whenever the link drives a non-transmit code
  p_quiet_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && ctl_o != CTL_TX) |-> d_o == '0);

endmodule

// File: tb/lk_tx_ctrl_bench.sv
module lk_tx_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_start, chain_next, src_valid, src_last;
  logic [1:0] tx_speed, ctl_i;
  logic [7:0] src_data;
  logic src_ready, ctl_oe, d_oe, lreq, err_speed, err_underrun;
  logic [1:0] ctl_o;
  logic [3:0] d_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lk_tx_ctrl u_lk_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_speed(tx_speed),
    .chain_next(chain_next), .src_data(src_data), .src_valid(src_valid),
    .src_last(src_last), .src_ready(src_ready), .ctl_i(ctl_i), .ctl_o(ctl_o),
    .ctl_oe(ctl_oe), .d_o(d_o), .d_oe(d_oe), .lreq(lreq),
    .err_speed(err_speed), .err_underrun(err_underrun)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       st;
    logic [1:0] ci;
    logic       v;
    logic [7:0] dat;
    logic       lst;
    logic       chn;
    logic       e_lreq;
    logic       e_oe;
    logic [1:0] e_ctl;
    logic [3:0] e_d;
    logic       e_rdy;
  } row_t;

  // rows 0-9: single packet, no hold (R1 R2 R4 R5); rows 10-26: hold,
  // chained packet (R3 R6) and a start pulse during transfer (R10)
  localparam row_t TBL [27] = '{
    '{4'd1, 1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd1, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd1, 1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd2, 1'b0, 2'b00, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b1},
    '{4'd4, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 4'hA, 1'b0},
    '{4'd4, 1'b0, 2'b00, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 4'h5, 1'b1},
    '{4'd4, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 4'h3, 1'b0},
    '{4'd4, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 4'hC, 1'b0},
    '{4'd5, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 4'h0, 1'b0},
    '{4'd5, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd1, 1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd1, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd1, 1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd2, 1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd2, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b1},
    '{4'd3, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 4'h0, 1'b1},
    '{4'd3, 1'b0, 2'b00, 1'b1, 8'h96, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 4'h0, 1'b1},
    '{4'd4, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 4'h9, 1'b0},
    '{4'd4, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 4'h6, 1'b0},
    '{4'd6, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 4'h0, 1'b0},
    '{4'd6, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd6, 1'b0, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b0},
    '{4'd6, 1'b0, 2'b00, 1'b1, 8'h7E, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b1},
    '{4'd10, 1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 4'h7, 1'b0},
    '{4'd6, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 4'hE, 1'b0},
    '{4'd5, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 4'h0, 1'b0},
    '{4'd10, 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_in(input logic st, input logic [1:0] ci, input logic v,
                          input logic [7:0] dat, input logic lst, input logic chn);
    @(negedge clk);
    tx_start = st; ctl_i = ci; src_valid = v; src_data = dat;
    src_last = lst; chain_next = chn;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tx_start = 1'b0; tx_speed = 2'b01; chain_next = 1'b0;
    src_data = '0; src_valid = 1'b0; src_last = 1'b0; ctl_i = 2'b00;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 lreq", lreq, 0);
    chk("R9 ctl_oe", ctl_oe, 0);
    chk("R9 d_oe", d_oe, 0);
    chk("R9 src_ready", src_ready, 0);
    chk("R9 err_speed", err_speed, 0);
    chk("R9 err_underrun", err_underrun, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 27; i++) begin
      drive_in(TBL[i].st, TBL[i].ci, TBL[i].v, TBL[i].dat, TBL[i].lst, TBL[i].chn);
      chk($sformatf("R%0d row %0d lreq", TBL[i].req, i), lreq, TBL[i].e_lreq);
      chk($sformatf("R%0d row %0d ctl_oe", TBL[i].req, i), ctl_oe, TBL[i].e_oe);
      chk($sformatf("R%0d row %0d d_oe", TBL[i].req, i), d_oe, TBL[i].e_oe);
      if (TBL[i].e_oe) begin
        chk($sformatf("R%0d row %0d ctl_o", TBL[i].req, i), ctl_o, TBL[i].e_ctl);
        chk($sformatf("R%0d row %0d d_o", TBL[i].req, i), d_o, TBL[i].e_d);
      end
      chk($sformatf("R%0d row %0d src_ready", TBL[i].req, i), src_ready, TBL[i].e_rdy);
    end

    // R7: chained last byte at a different speed
    drive_in(1, 2'b00, 0, 8'h00, 0, 0);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    drive_in(0, 2'b11, 0, 8'h00, 0, 0);
    tx_speed = 2'b10;
    drive_in(0, 2'b00, 1, 8'h55, 1, 1);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R7 err_speed pulse", err_speed, 1);
    chk("R7 first nibble", d_o, 4'h5);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R7 err_speed cleared", err_speed, 0);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R7 ends with idle ctl_o", ctl_o, 2'b00);
    chk("R7 ends with idle ctl_oe", ctl_oe, 1);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R7 released", ctl_oe, 0);
    drive_in(0, 2'b11, 0, 8'h00, 0, 0);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R7 no rechain takeover", ctl_oe, 0);
    tx_speed = 2'b01;

    // R8: source stall inside a packet
    drive_in(1, 2'b00, 0, 8'h00, 0, 0);
    drive_in(0, 2'b11, 0, 8'h00, 0, 0);
    drive_in(0, 2'b00, 1, 8'hF0, 0, 0);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R8 upper nibble", d_o, 4'hF);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R8 lower nibble", d_o, 4'h0);
    chk("R8 still transmit", ctl_o, 2'b10);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R8 err_underrun", err_underrun, 1);
    chk("R8 idle code", ctl_o, 2'b00);
    chk("R8 driving", ctl_oe, 1);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R8 released", ctl_oe, 0);
    chk("R8 flag cleared", err_underrun, 0);

    // R9: reset in the middle of a transfer
    drive_in(1, 2'b00, 0, 8'h00, 0, 0);
    drive_in(0, 2'b11, 0, 8'h00, 0, 0);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R9 hold before reset", ctl_oe, 1);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset ctl_oe", ctl_oe, 0);
    chk("R9 async reset src_ready", src_ready, 0);
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    rst_n = 1'b1;
    drive_in(0, 2'b00, 0, 8'h00, 0, 0);
    chk("R9 stays released", lreq, 0);

    finish_run();
  end

endmodule